// File: doc/BRIEF.md
# Translation Context Control and Fault Bank

This block is the register bank of a small I/O memory-management unit. It holds up to eight translation contexts, each in its own 64-byte window of a word-addressed host port. A context carries a control word (translation enable, interrupt enable, TLB invalidation request), four plain configuration words that the translation engine consumes, a fault status word and a 64-bit captured fault address. A single interrupt line summarises every context whose interrupt is enabled and whose status shows a fault.

An invalidation is started by writing the control word with its flush bit set. The bank sends a one-cycle request to the TLB for that context and keeps the flush bit reading as 1 until the TLB acknowledges. Software polls that bit to learn when invalidation is complete. The translation engine reports faults on a separate input carrying the context number, a type vector and the faulting address. Only the first fault after a clear is kept. Any write to the status word clears the flags and wipes the captured address, so software must read the address first.

Top module: `mmu_ctx_bank`

## Requirements
- R1: After reset every context's control and status words read 0, `irq` is 0 and `flush_req` is all zeros.
- R2: A write to a context's control word (offset 0x00) sets translation enable from data bit 0 and interrupt enable from data bit 2, and both read back in the same positions. Writing 0 disables the context.
- R3: A control write with data bit 1 set, made while no invalidation is pending, raises `flush_req[n]` for exactly the one cycle after the write edge. From that same edge the control word reads bit 1 as 1.
- R4: Control bit 1 keeps reading 1 until `flush_ack[n]` is seen while the request is outstanding, and reads 0 from the edge that samples the acknowledge. While the invalidation is pending, a further control write with bit 1 set issues no new request, and a write with bit 1 clear does not cancel it.
- R5: A fault report for an enabled context whose status is 0 and whose type vector is non-zero is captured at the next edge. Status (offset 0x20) then holds type bit 0 at bit 0 (translation fault), type bit 1 at bit 1 (permission fault), type bit 2 at bit 2 (walk abort) and type bit 3 at bit 4 (multiple hit). The address reads at 0x30 (bits 31:0) and 0x34 (bits 63:32).
- R6: While status is non-zero, later faults change neither the status nor the captured address. Faults aimed at a disabled context are ignored.
- R7: Any write to the status word, whatever its data, clears all flags. Afterwards both fault address words read 0.
- R8: When a status write and a fault report for the same context fall on the same edge, the write wins: status and address read 0 afterwards.
- R9: `irq` is 1 exactly when some context has interrupt enable set and a non-zero status.
- R10: The configuration words at offsets 0x08, 0x10, 0x14 and 0x28 store and read back all 32 bits.
- R11: Offsets other than the eight named ones, and context windows at or above `NUM_CTX`, read as 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe for the addressed word |
| addr | input | ADDR_W | Host byte address; bits above 5 pick the context |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| fault_valid | input | 1 | Fault report strobe |
| fault_ctx | input | ADDR_W-6 | Context the fault belongs to |
| fault_type | input | 4 | Fault type vector (translation, permission, abort, multi-hit) |
| fault_addr | input | 64 | Faulting address |
| flush_req | output | NUM_CTX | One-cycle invalidation request per context |
| flush_ack | input | NUM_CTX | Invalidation done, per context |
| irq | output | 1 | Combined fault interrupt |

## Verification
Two functions can land on the same edge: a host write that clears a context's status, and a fault report aimed at that context. The bench provokes this by driving the write strobe and the fault strobe in the same cycle, once with status already set and once with it clear. It judges the outcome by reading status and both address words, which must all be 0. A second overlap comes from host control writes made while an invalidation is still pending. These are judged by counting request pulses and by reading the flush bit before and after the acknowledge.

// File: rtl/mmu_ctx_pkg.sv
package mmu_ctx_pkg;

    localparam int CTX_SPAN_W = 6;

    localparam logic [5:0] OFF_CTRL  = 6'h00;
    localparam logic [5:0] OFF_XLAT  = 6'h08;
    localparam logic [5:0] OFF_TBL_L = 6'h10;
    localparam logic [5:0] OFF_TBL_H = 6'h14;
    localparam logic [5:0] OFF_STAT  = 6'h20;
    localparam logic [5:0] OFF_ATTR  = 6'h28;
    localparam logic [5:0] OFF_FLT_L = 6'h30;
    localparam logic [5:0] OFF_FLT_H = 6'h34;

    typedef enum logic [1:0] {
        FL_IDLE  = 2'd0,
        FL_ISSUE = 2'd1,
        FL_WAIT  = 2'd2
    } flush_state_e;

    // type vector {multi, abort, perm, xlat} -> status {multi,0,abort,perm,xlat}
    function automatic logic [4:0] flt_to_stat(input logic [3:0] t);
        return {t[3], 1'b0, t[2:0]};
    endfunction

endpackage

// File: rtl/mmu_ctx_flush_fsm.sv
module mmu_ctx_flush_fsm
    import mmu_ctx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ack,
    output logic req,
    output logic busy
);

    flush_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE:  if (start) state_d = FL_ISSUE;
            FL_ISSUE: state_d = FL_WAIT;
            FL_WAIT:  if (ack) state_d = FL_IDLE;
            default:  state_d = FL_IDLE;
        endcase
    end

    always_comb begin
        req  = 1'b0;
        busy = 1'b1;
        unique case (state_q)
            FL_IDLE:  busy = 1'b0;
            FL_ISSUE: req  = 1'b1;
            FL_WAIT:  req  = 1'b0;
            default:  busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/mmu_ctx_slot.sv
module mmu_ctx_slot
    import mmu_ctx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FADDR_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [5:0]         off,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               flt_hit,
    input  logic [3:0]         flt_type,
    input  logic [FADDR_W-1:0] flt_addr,
    input  logic               flush_ack,
    output logic               flush_req,
    output logic [DATA_W-1:0]  rdata,
    output logic               en,
    output logic               ie,
    output logic               flag,
    output logic               busy
);

    localparam int ST_W = 5;

    logic [DATA_W-1:0]  xlat_q, tbl_l_q, tbl_h_q, attr_q;
    logic [ST_W-1:0]    stat_q;
    logic [FADDR_W-1:0] faddr_q;
    logic               wr_ctrl, wr_stat, take_fault;

    assign wr_ctrl    = wr && (off == OFF_CTRL);
    assign wr_stat    = wr && (off == OFF_STAT);
    assign take_fault = flt_hit && en && (stat_q == '0) && (flt_type != 4'd0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en      <= 1'b0;
            ie      <= 1'b0;
            xlat_q  <= '0;
            tbl_l_q <= '0;
            tbl_h_q <= '0;
            attr_q  <= '0;
            stat_q  <= '0;
            faddr_q <= '0;
        end else begin
            if (wr_ctrl) begin
                en <= wdata[0];
                ie <= wdata[2];
            end
            if (wr && off == OFF_XLAT)  xlat_q  <= wdata;
            if (wr && off == OFF_TBL_L) tbl_l_q <= wdata;
            if (wr && off == OFF_TBL_H) tbl_h_q <= wdata;
            if (wr && off == OFF_ATTR)  attr_q  <= wdata;
            if (wr_stat) begin
                stat_q  <= '0;
                faddr_q <= '0;
            end else if (take_fault) begin
                stat_q  <= flt_to_stat(flt_type);
                faddr_q <= flt_addr;
            end
        end
    end

    mmu_ctx_flush_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_ctrl && wdata[1]),
        .ack   (flush_ack),
        .req   (flush_req),
        .busy  (busy)
    );

    assign flag = (stat_q != '0);

    always_comb begin
        case (off)
            OFF_CTRL:  rdata = {{(DATA_W-3){1'b0}}, ie, busy, en};
            OFF_XLAT:  rdata = xlat_q;
            OFF_TBL_L: rdata = tbl_l_q;
            OFF_TBL_H: rdata = tbl_h_q;
            OFF_STAT:  rdata = {{(DATA_W-ST_W){1'b0}}, stat_q};
            OFF_ATTR:  rdata = attr_q;
            OFF_FLT_L: rdata = faddr_q[DATA_W-1:0];
            OFF_FLT_H: rdata = faddr_q[FADDR_W-1:DATA_W];
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/mmu_ctx_bank.sv
module mmu_ctx_bank
    import mmu_ctx_pkg::*;
#(
    parameter int NUM_CTX = 8,
    parameter int ADDR_W  = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    input  logic               fault_valid,
    input  logic [ADDR_W-7:0]  fault_ctx,
    input  logic [3:0]         fault_type,
    input  logic [63:0]        fault_addr,
    output logic [NUM_CTX-1:0] flush_req,
    input  logic [NUM_CTX-1:0] flush_ack,
    output logic               irq
);

    localparam int IDX_W = ADDR_W - CTX_SPAN_W;

    logic [IDX_W-1:0]   idx;
    logic [5:0]         off;
    logic [31:0]        words [NUM_CTX];
    logic [NUM_CTX-1:0] ctx_en, ctx_ie, ctx_flag, ctx_busy;

    assign idx = addr[ADDR_W-1:CTX_SPAN_W];
    assign off = addr[CTX_SPAN_W-1:0];

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
        mmu_ctx_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr        (wr_en && (idx == IDX_W'(i))),
            .off       (off),
            .wdata     (wdata),
            .flt_hit   (fault_valid && (fault_ctx == IDX_W'(i))),
            .flt_type  (fault_type),
            .flt_addr  (fault_addr),
            .flush_ack (flush_ack[i]),
            .flush_req (flush_req[i]),
            .rdata     (words[i]),
            .en        (ctx_en[i]),
            .ie        (ctx_ie[i]),
            .flag      (ctx_flag[i]),
            .busy      (ctx_busy[i])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CTX; i++) begin
            if (idx == IDX_W'(i)) rdata = words[i];
        end
    end

    assign irq = |(ctx_ie & ctx_flag);

endmodule

// File: rtl/mmu_ctx_bank_chk.sv
module mmu_ctx_bank_chk #(
    parameter int NUM_CTX = 8,
    parameter int ADDR_W  = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic               fault_valid,
    input logic [ADDR_W-7:0]  fault_ctx,
    input logic [3:0]         fault_type,
    input logic [NUM_CTX-1:0] flush_req,
    input logic               irq,
    input logic [NUM_CTX-1:0] ctx_en,
    input logic [NUM_CTX-1:0] ctx_flag,
    input logic [NUM_CTX-1:0] ctx_busy
);

    localparam int IDX_W = ADDR_W - 6;

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_chk
        logic stat_wr;
        logic flt_here;
        assign stat_wr  = wr_en && (addr[5:0] == 6'h20) && (addr[ADDR_W-1:6] == IDX_W'(i));
        assign flt_here = fault_valid && (fault_ctx == IDX_W'(i)) && (fault_type != 4'd0);

        AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            flush_req[i] |=> !flush_req[i]); // R3

        AST_REQ_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
            flush_req[i] |=> ctx_busy[i]); // R4

        AST_FAULT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            (flt_here && ctx_en[i] && !stat_wr) |=> ctx_flag[i]); // R5

        AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (ctx_flag[i] && !stat_wr) |=> ctx_flag[i]); // R6

        AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            stat_wr |=> !ctx_flag[i]); // R8
    end

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_flag == '0) |-> !irq); // R9

endmodule

bind mmu_ctx_bank mmu_ctx_bank_chk #(.NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .fault_valid (fault_valid),
    .fault_ctx   (fault_ctx),
    .fault_type  (fault_type),
    .flush_req   (flush_req),
    .irq         (irq),
    .ctx_en      (ctx_en),
    .ctx_flag    (ctx_flag),
    .ctx_busy    (ctx_busy)
);

// File: tb/mmu_ctx_bank_tb.sv
`timescale 1ns/1ps
module mmu_ctx_bank_tb;

    localparam int NC = 6;
    localparam int AW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          fault_valid = 1'b0;
    logic [2:0]    fault_ctx = '0;
    logic [3:0]    fault_type = '0;
    logic [63:0]   fault_addr = '0;
    logic [NC-1:0] flush_req;
    logic [NC-1:0] flush_ack = '0;
    logic          irq;

    int total = 0;
    int bad = 0;
    int pulses = 0;

    always #2 clk = ~clk;

    mmu_ctx_bank #(.NUM_CTX(NC), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .fault_valid(fault_valid), .fault_ctx(fault_ctx),
        .fault_type(fault_type), .fault_addr(fault_addr), .flush_req(flush_req),
        .flush_ack(flush_ack), .irq(irq)
    );

    always @(negedge clk) if (rst_n) pulses += $countones(flush_req);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int c, input int o, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(c * 64 + o); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int c, input int o, output logic [31:0] d);
        @(negedge clk);
        addr = AW'(c * 64 + o);
        #1 d = rdata;
    endtask

    task automatic flt(input int c, input logic [3:0] t, input logic [63:0] a);
        @(negedge clk);
        fault_valid = 1'b1; fault_ctx = 3'(c); fault_type = t; fault_addr = a;
        @(negedge clk);
        fault_valid = 1'b0;
    endtask

    function automatic logic [31:0] cfg_pat(input int c, input int o);
        return (32'(c) << 24) ^ (32'(o) << 16) ^ (32'hA5C3 + 32'(c * 7 + o));
    endfunction

    function automatic logic [31:0] stat_of(input logic [3:0] t);
        return (32'(t[3]) << 4) | 32'(t[2:0]);
    endfunction

    initial begin
        #800000;
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [63:0] a;
        int p0;
        int offs [4] = '{8, 16, 20, 40};
        int junk [6] = '{4, 12, 24, 36, 60, 2};

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state across every window
        for (int c = 0; c < 8; c++) begin
            rd(c, 0, v);  chk("R1 ctrl", v, 0);
            rd(c, 32, v); chk("R1 stat", v, 0);
        end
        chk("R1 irq", irq, 0);
        chk("R1 flush_req", flush_req, 0);

        // R10 config words, all contexts
        for (int c = 0; c < NC; c++)
            for (int k = 0; k < 4; k++) wr(c, offs[k], cfg_pat(c, offs[k]));
        for (int c = 0; c < NC; c++)
            for (int k = 0; k < 4; k++) begin
                rd(c, offs[k], v); chk("R10 cfg readback", v, cfg_pat(c, offs[k]));
            end

        // R11 missing contexts and unmapped offsets
        for (int c = NC; c < 8; c++)
            for (int k = 0; k < 4; k++) begin
                wr(c, offs[k], 32'hFFFF_FFFF);
                rd(c, offs[k], v); chk("R11 absent ctx", v, 0);
            end
        for (int k = 0; k < 6; k++) begin
            wr(0, junk[k], 32'hFFFF_FFFF);
            rd(0, junk[k], v); chk("R11 unmapped offset", v, 0);
        end
        for (int c = 0; c < NC; c++)
            for (int k = 0; k < 4; k++) begin
                rd(c, offs[k], v); chk("R11 untouched", v, cfg_pat(c, offs[k]));
            end
        rd(0, 0, v); chk("R11 ctrl untouched", v, 0);

        // R2 control bits
        wr(4, 0, 32'h5); rd(4, 0, v); chk("R2 en+ie", v, 32'h5);
        wr(4, 0, 32'h1); rd(4, 0, v); chk("R2 en only", v, 32'h1);
        wr(4, 0, 32'h0); rd(4, 0, v); chk("R2 disable", v, 32'h0);

        // R3 R4 flush sweep with random acknowledge delays
        for (int c = 0; c < NC; c++) begin
            int d = $urandom_range(1, 12);
            p0 = pulses;
            wr(c, 0, 32'h3);
            chk("R3 req pulse", flush_req, NC'(1) << c);
            rd(c, 0, v);
            chk("R3 req one cycle", flush_req, 0);
            chk("R3 flush reads 1", v, 32'h3);
            repeat (d) @(negedge clk);
            rd(c, 0, v); chk("R4 pending before ack", v, 32'h3);
            @(negedge clk); flush_ack = NC'(1) << c;
            @(negedge clk); flush_ack = '0;
            rd(c, 0, v); chk("R4 clear after ack", v, 32'h1);
            chk("R3 single pulse", pulses - p0, 1);
            wr(c, 0, 32'h0);
        end

        // R4 writes while pending
        p0 = pulses;
        wr(5, 0, 32'h2);
        wr(5, 0, 32'h2);
        wr(5, 0, 32'h1);
        rd(5, 0, v); chk("R4 pending kept", v, 32'h3);
        chk("R4 no extra request", pulses - p0, 1);
        @(negedge clk); flush_ack = NC'(1) << 5;
        @(negedge clk); flush_ack = '0;
        rd(5, 0, v); chk("R4 done", v, 32'h1);
        wr(5, 0, 32'h0);

        // R5 R7 type sweep on context 2
        wr(2, 0, 32'h1);
        for (int t = 1; t < 16; t++) begin
            a = (64'(t) << 36) | (64'(t) * 64'h1020_3041);
            flt(2, 4'(t), a);
            rd(2, 32, v); chk("R5 status map", v, stat_of(4'(t)));
            rd(2, 48, v); chk("R5 addr low", v, a[31:0]);
            rd(2, 52, v); chk("R5 addr high", v, a[63:32]);
            wr(2, 32, 32'(t) * 32'h1111_1111);
            rd(2, 32, v); chk("R7 status cleared", v, 0);
            rd(2, 48, v); chk("R7 addr low zero", v, 0);
            rd(2, 52, v); chk("R7 addr high zero", v, 0);
        end

        // R6 first fault held; disabled context ignores faults
        flt(2, 4'h1, 64'h0000_0012_3456_7000);
        flt(2, 4'h4, 64'h0000_00FF_EEEE_0000);
        rd(2, 32, v); chk("R6 status held", v, 32'h1);
        rd(2, 48, v); chk("R6 addr held", v, 32'h3456_7000);
        wr(2, 32, 32'h0);
        flt(3, 4'h2, 64'h1234);
        rd(3, 32, v); chk("R6 disabled ignores", v, 0);
        rd(3, 48, v); chk("R6 disabled addr", v, 0);

        // R8 same-edge clear and fault, status clear then status set
        for (int pre = 0; pre < 2; pre++) begin
            if (pre == 1) flt(2, 4'h8, 64'hABCD);
            @(negedge clk);
            wr_en = 1'b1; addr = AW'(2 * 64 + 32); wdata = 32'h0;
            fault_valid = 1'b1; fault_ctx = 3'd2; fault_type = 4'h2; fault_addr = 64'h55AA;
            @(negedge clk);
            wr_en = 1'b0; fault_valid = 1'b0;
            rd(2, 32, v); chk("R8 clear wins status", v, 0);
            rd(2, 48, v); chk("R8 clear wins addr", v, 0);
        end

        // R9 interrupt combining
        wr(1, 0, 32'h5);
        chk("R9 no flag", irq, 0);
        flt(1, 4'h2, 64'h40);
        chk("R9 ie and flag", irq, 1);
        flt(2, 4'h1, 64'h80);
        wr(1, 0, 32'h1);
        chk("R9 flags without ie", irq, 0);
        wr(1, 0, 32'h5);
        chk("R9 ie back", irq, 1);
        wr(1, 32, 32'h0);
        chk("R9 cleared", irq, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule